// File: doc/BRIEF.md
# TCP Offload Register Control Sequencer

This block drives a TCP offload engine through its register port (address, write strobe, write data and read data). It is built for a server that opens passively. A debounced press of a start switch makes it load the engine's network identity: local MAC, local IP, local port and remote IP. It then takes the engine out of reset and polls the engine's busy flag until initialization is done. After that it waits for a peer to open a connection.

A mode input selects what happens once the connection is open. In transmit mode the block programs the transfer length and the segment length, issues a send command, waits until the engine is idle again, and then closes the connection actively. In receive mode the block writes nothing and waits for the peer to close. Both paths return to waiting for the next connection, so the engine stays configured and serves one connection after another.

All register-port outputs come from flops. A busy poll throws away the read data until the command-register address has had time to reach the engine and come back.

Top module: `toe_ctrl_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, the block writes nothing (write strobe 0) and drives address 0.
- R2: A start level change reaches the sequencer only after it has held for DEB_CYCLES clocks. Only the rising edge of the filtered level starts the configuration. A shorter pulse has no effect, and neither does releasing the switch.
- R3: After a start, the block makes eight writes on consecutive cycles, in this order: RST(0)=1, SML(2)=low 32 bits of the local MAC, SMH(3)=high 16 bits of the local MAC, SIP(5)=local IP, DIP(4)=remote IP, SPN(7)=local port, DPN(6)=0, TDL(8)=0. With the default parameters the data words are 0x1, 0x02030405, 0x0001, 0xC0A80B2A, 0xC0A80B19, 0xFA0 (4000), 0x0 and 0x0.
- R4: Next the block writes RST(0)=0. It then drives address CMD(1) with the strobe low, and it does not leave the poll until bit 0 of the read data is 0. Read data is taken as valid one cycle after the address. The first two poll cycles are ignored, so the block never writes while the engine reports busy.
- R5: In the wait-open state the block makes no write as long as conn_on is 0.
- R6: When conn_on is 1 and mode_rx is 0, the block writes TDL(8)=tx_total_len, then PKL(9)=tx_pkt_len (zero-extended), then CMD(1)=0. Each length is sampled in the cycle its write is issued.
- R7: Once busy clears after the send command, the block writes CMD(1)=3 (close). It polls busy again and then goes back to wait-open.
- R8: When conn_on is 1 and mode_rx is 1, the block makes no write until conn_on falls to 0, and then goes back to wait-open. A later transmit connection is then served as in R6.
- R9: Every write uses one of the addresses 0 to 9 (RST=0, CMD=1, SML=2, SMH=3, DIP=4, SIP=5, DPN=6, SPN=7, TDL=8, PKL=9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_sw | input | 1 | Raw start switch level |
| mode_rx | input | 1 | 0 = transmit session, 1 = receive session |
| conn_on | input | 1 | Connection status from the engine |
| tx_total_len | input | 32 | Total bytes to send, written to TDL |
| tx_pkt_len | input | 16 | Segment size, written to PKL |
| reg_addr | output | 4 | Register address |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_data | output | 32 | Register write data |
| reg_rd_data | input | 32 | Register read data, one cycle after the address |

## Verification
The bench builds the block with DEB_CYCLES=8 instead of the default of about a million clocks. This puts the switch filter within reach of a short run, including a glitch shorter than the window and a release that must not retrigger. The address and identity parameters keep their defaults, so the bench checks the exact configuration words. A behavioural engine in the bench holds busy for tens of cycles after a reset release or a command, which exercises the discarded poll cycles and the wait for busy to clear.

// File: rtl/toe_seq_pkg.sv
package toe_seq_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_RST = 4'd0;
  localparam logic [ADDR_W-1:0] A_CMD = 4'd1;
  localparam logic [ADDR_W-1:0] A_SML = 4'd2;
  localparam logic [ADDR_W-1:0] A_SMH = 4'd3;
  localparam logic [ADDR_W-1:0] A_DIP = 4'd4;
  localparam logic [ADDR_W-1:0] A_SIP = 4'd5;
  localparam logic [ADDR_W-1:0] A_DPN = 4'd6;
  localparam logic [ADDR_W-1:0] A_SPN = 4'd7;
  localparam logic [ADDR_W-1:0] A_TDL = 4'd8;
  localparam logic [ADDR_W-1:0] A_PKL = 4'd9;

  localparam logic [DATA_W-1:0] CMD_SEND  = 32'd0;
  localparam logic [DATA_W-1:0] CMD_CLOSE = 32'd3;

  localparam int CFG_WRITES = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CFG,
    ST_REL,
    ST_POLL,
    ST_OPEN,
    ST_TDL,
    ST_PKL,
    ST_SEND,
    ST_CLOSE,
    ST_RXWAIT
  } seq_state_t;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_op_t;
endpackage

// File: rtl/toe_start_filter.sv
module toe_start_filter #(
  parameter int DEB_CYCLES = 1 << 20,
  localparam int CNT_W = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  output logic start_pulse
);
  logic [1:0]       sync_q;
  logic             level_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q      <= '0;
      level_q     <= 1'b0;
      cnt_q       <= '0;
      start_pulse <= 1'b0;
    end else begin
      sync_q      <= {sync_q[0], raw_in};
      start_pulse <= 1'b0;
      if (sync_q[1] == level_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_W'(DEB_CYCLES - 1)) begin
        cnt_q       <= '0;
        level_q     <= sync_q[1];
        start_pulse <= sync_q[1];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/toe_cfg_table.sv
module toe_cfg_table
  import toe_seq_pkg::*;
#(
  parameter logic [47:0] LOCAL_MAC  = 48'h00_01_02_03_04_05,
  parameter logic [31:0] LOCAL_IP   = 32'hC0A8_0B2A,
  parameter logic [15:0] LOCAL_PORT = 16'd4000,
  parameter logic [31:0] REMOTE_IP  = 32'hC0A8_0B19,
  localparam int IDX_W = $clog2(CFG_WRITES)
) (
  input  logic [IDX_W-1:0] idx,
  output wr_op_t           op
);
  wr_op_t table_q [CFG_WRITES];

  always_comb begin
    table_q[0] = '{addr: A_RST, data: 32'd1};
    table_q[1] = '{addr: A_SML, data: LOCAL_MAC[31:0]};
    table_q[2] = '{addr: A_SMH, data: {16'd0, LOCAL_MAC[47:32]}};
    table_q[3] = '{addr: A_SIP, data: LOCAL_IP};
    table_q[4] = '{addr: A_DIP, data: REMOTE_IP};
    table_q[5] = '{addr: A_SPN, data: {16'd0, LOCAL_PORT}};
    table_q[6] = '{addr: A_DPN, data: 32'd0};
    table_q[7] = '{addr: A_TDL, data: 32'd0};
    op = table_q[idx];
  end
endmodule

// File: rtl/toe_busy_wait.sv
module toe_busy_wait #(
  parameter int SKIP = 2,
  localparam int CW = $clog2(SKIP + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic busy_bit,
  output logic done
);
  logic [CW-1:0] age_q;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      age_q <= '0;
    end else if (age_q != CW'(SKIP)) begin
      age_q <= age_q + 1'b1;
    end
  end

  assign done = active && (age_q == CW'(SKIP)) && !busy_bit;
endmodule

// File: rtl/toe_ctrl_seq.sv
module toe_ctrl_seq
  import toe_seq_pkg::*;
#(
  parameter int          DEB_CYCLES = 1 << 20,
  parameter int          PKT_W      = 16,
  parameter logic [47:0] LOCAL_MAC  = 48'h00_01_02_03_04_05,
  parameter logic [31:0] LOCAL_IP   = 32'hC0A8_0B2A,
  parameter logic [15:0] LOCAL_PORT = 16'd4000,
  parameter logic [31:0] REMOTE_IP  = 32'hC0A8_0B19,
  localparam int IDX_W = $clog2(CFG_WRITES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_sw,
  input  logic              mode_rx,
  input  logic              conn_on,
  input  logic [31:0]       tx_total_len,
  input  logic [PKT_W-1:0]  tx_pkt_len,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_wr_en,
  output logic [DATA_W-1:0] reg_wr_data,
  input  logic [DATA_W-1:0] reg_rd_data
);
  seq_state_t       state_q;
  seq_state_t       ret_q;
  logic [IDX_W-1:0] idx_q;
  logic             start_pulse;
  logic             poll_done;
  wr_op_t           cfg_op;

  toe_start_filter #(.DEB_CYCLES(DEB_CYCLES)) u_start (
    .clk(clk), .rst(rst), .raw_in(start_sw), .start_pulse(start_pulse)
  );

  toe_cfg_table #(
    .LOCAL_MAC(LOCAL_MAC), .LOCAL_IP(LOCAL_IP),
    .LOCAL_PORT(LOCAL_PORT), .REMOTE_IP(REMOTE_IP)
  ) u_cfg (
    .idx(idx_q), .op(cfg_op)
  );

  toe_busy_wait #(.SKIP(2)) u_poll (
    .clk(clk), .rst(rst), .active(state_q == ST_POLL),
    .busy_bit(reg_rd_data[0]), .done(poll_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      ret_q       <= ST_OPEN;
      idx_q       <= '0;
      reg_addr    <= '0;
      reg_wr_en   <= 1'b0;
      reg_wr_data <= '0;
    end else begin
      reg_wr_en <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          idx_q <= '0;
          if (start_pulse) state_q <= ST_CFG;
        end
        ST_CFG: begin
          reg_wr_en   <= 1'b1;
          reg_addr    <= cfg_op.addr;
          reg_wr_data <= cfg_op.data;
          if (idx_q == IDX_W'(CFG_WRITES - 1)) state_q <= ST_REL;
          else idx_q <= idx_q + 1'b1;
        end
        ST_REL: begin
          reg_wr_en   <= 1'b1;
          reg_addr    <= A_RST;
          reg_wr_data <= '0;
          ret_q       <= ST_OPEN;
          state_q     <= ST_POLL;
        end
        ST_POLL: begin
          reg_addr <= A_CMD;
          if (poll_done) state_q <= ret_q;
        end
        ST_OPEN: begin
          if (conn_on) state_q <= mode_rx ? ST_RXWAIT : ST_TDL;
        end
        ST_TDL: begin
          reg_wr_en   <= 1'b1;
          reg_addr    <= A_TDL;
          reg_wr_data <= tx_total_len;
          state_q     <= ST_PKL;
        end
        ST_PKL: begin
          reg_wr_en   <= 1'b1;
          reg_addr    <= A_PKL;
          reg_wr_data <= DATA_W'(tx_pkt_len);
          state_q     <= ST_SEND;
        end
        ST_SEND: begin
          reg_wr_en   <= 1'b1;
          reg_addr    <= A_CMD;
          reg_wr_data <= CMD_SEND;
          ret_q       <= ST_CLOSE;
          state_q     <= ST_POLL;
        end
        ST_CLOSE: begin
          reg_wr_en   <= 1'b1;
          reg_addr    <= A_CMD;
          reg_wr_data <= CMD_CLOSE;
          ret_q       <= ST_OPEN;
          state_q     <= ST_POLL;
        end
        ST_RXWAIT: begin
          if (!conn_on) state_q <= ST_OPEN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/toe_ctrl_seq_chk.sv
module toe_ctrl_seq_chk
  import toe_seq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input seq_state_t        st,
  input logic              start_pulse,
  input logic              conn_on,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr_en
);
  logic seen_clk;
  always_ff @(posedge clk) seen_clk <= 1'b1;

  // R1: first cycle after reset is quiet
  p_reset_quiet_r1: assert property (@(posedge clk)
    seen_clk && !rst && $past(rst) |-> !reg_wr_en && reg_addr == '0 && st == ST_IDLE);

  // R2: idle holds unless the filtered edge arrives
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    st == ST_IDLE && !start_pulse |=> st == ST_IDLE);

  // R4: polling cycles address CMD with no write
  p_poll_reads_r4: assert property (@(posedge clk) disable iff (rst)
    st == ST_POLL && $past(st) == ST_POLL |-> reg_addr == A_CMD && !reg_wr_en);

  // R5: wait-open is held while the connection is down
  p_open_gate_r5: assert property (@(posedge clk) disable iff (rst)
    st == ST_OPEN && !conn_on |=> st == ST_OPEN && !reg_wr_en);

  // R8: receive session makes no writes
  p_rx_silent_r8: assert property (@(posedge clk) disable iff (rst)
    st == ST_RXWAIT |-> !reg_wr_en);

  // R9: write address within the map
  p_addr_map_r9: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |-> reg_addr <= A_PKL);
endmodule

bind toe_ctrl_seq toe_ctrl_seq_chk u_chk (
  .clk(clk), .rst(rst), .st(state_q), .start_pulse(start_pulse),
  .conn_on(conn_on), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en)
);

// File: tb/toe_ctrl_seq_test.sv
module toe_ctrl_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_sw = 1'b0;
  logic        mode_rx = 1'b0;
  logic        conn_on = 1'b0;
  logic [31:0] tx_total_len = '0;
  logic [15:0] tx_pkt_len = '0;
  logic [3:0]  reg_addr;
  logic        reg_wr_en;
  logic [31:0] reg_wr_data;
  logic [31:0] reg_rd_data;

  int total = 0;
  int bad = 0;
  int writes_seen = 0;
  logic [35:0] expq[$];

  logic       eng_busy;
  int         eng_cnt;

  always #2 clk = ~clk;

  toe_ctrl_seq #(.DEB_CYCLES(8)) uut (
    .clk(clk), .rst(rst), .start_sw(start_sw), .mode_rx(mode_rx),
    .conn_on(conn_on), .tx_total_len(tx_total_len), .tx_pkt_len(tx_pkt_len),
    .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data)
  );

  // behavioural engine: busy after reset release or a command, one-cycle read latency
  always @(posedge clk) begin
    if (rst) begin
      eng_busy    <= 1'b0;
      eng_cnt     <= 0;
      reg_rd_data <= '0;
    end else begin
      reg_rd_data <= (reg_addr == 4'd1) ? {31'd0, eng_busy} : 32'hDEAD0000;
      if (eng_cnt > 0) begin
        eng_cnt <= eng_cnt - 1;
        if (eng_cnt == 1) eng_busy <= 1'b0;
      end
      if (reg_wr_en && reg_addr == 4'd0 && reg_wr_data == 32'd0) begin
        eng_busy <= 1'b1; eng_cnt <= 15;
      end
      if (reg_wr_en && reg_addr == 4'd1) begin
        eng_busy <= 1'b1; eng_cnt <= (reg_wr_data == 32'd3) ? 10 : 25;
      end
    end
  end

  task automatic expect_wr(input logic [3:0] a, input logic [31:0] d);
    expq.push_back({a, d});
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every write
  always @(negedge clk) begin
    if (!rst && reg_wr_en) begin
      writes_seen++;
      if (expq.size() == 0) begin
        check(1'b0, "R5/R8 unexpected write", {reg_addr, reg_wr_data}, 64'h0);
      end else begin
        logic [35:0] e;
        e = expq.pop_front();
        check({reg_addr, reg_wr_data} == e, "R3/R4/R6/R7 write", {reg_addr, reg_wr_data}, e);
      end
      check(!eng_busy, "R4/R7 write while busy", eng_busy, 0);
      check(reg_addr <= 4'd9, "R9 address map", reg_addr, 9);
    end
  end

  task automatic drain(input string req);
    int n = 0;
    while (expq.size() != 0 && n < 2000) begin
      @(negedge clk); n++;
    end
    check(expq.size() == 0, req, expq.size(), 0);
  endtask

  task automatic quiet(input int cycles, input string req);
    int w0;
    w0 = writes_seen;
    repeat (cycles) @(negedge clk);
    check(writes_seen == w0, req, writes_seen - w0, 0);
  endtask

  task automatic tx_session(input logic [31:0] tl, input logic [15:0] pl, input string req);
    tx_total_len = tl; tx_pkt_len = pl; mode_rx = 1'b0;
    expect_wr(4'd8, tl);
    expect_wr(4'd9, {16'd0, pl});
    expect_wr(4'd1, 32'd0);
    expect_wr(4'd1, 32'd3);
    conn_on = 1'b1;
    drain(req);
    conn_on = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(!reg_wr_en && reg_addr == 4'd0, "R1 reset outputs", {reg_wr_en, reg_addr}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!reg_wr_en && reg_addr == 4'd0, "R1 after reset", {reg_wr_en, reg_addr}, 0);

    // R2: short glitch ignored
    start_sw = 1'b1; repeat (3) @(negedge clk); start_sw = 1'b0;
    quiet(40, "R2 glitch ignored");

    // R3 and R4: configuration then reset release
    expect_wr(4'd0, 32'd1);
    expect_wr(4'd2, 32'h02030405);
    expect_wr(4'd3, 32'h00000001);
    expect_wr(4'd5, 32'hC0A80B2A);
    expect_wr(4'd4, 32'hC0A80B19);
    expect_wr(4'd7, 32'd4000);
    expect_wr(4'd6, 32'd0);
    expect_wr(4'd8, 32'd0);
    expect_wr(4'd0, 32'd0);
    start_sw = 1'b1;
    drain("R3 configuration");
    repeat (20) @(negedge clk);
    start_sw = 1'b0;
    // R2: release and held level give no new start; R5: conn_on low gives no write
    quiet(60, "R2/R5 no write while waiting");

    // R6/R7: two transmit sessions with distinct lengths
    tx_session(32'd5000, 16'd1460, "R6/R7 transmit 1");
    tx_session(32'h00012345, 16'd8960, "R6/R7 transmit 2");

    // R8: receive session is silent, then back to wait-open
    mode_rx = 1'b1; conn_on = 1'b1;
    quiet(50, "R8 receive silent");
    conn_on = 1'b0;
    quiet(10, "R8 close silent");
    tx_session(32'd777, 16'd512, "R8 return to wait-open");

    check(expq.size() == 0, "R6 scoreboard empty", expq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule